// File: doc/BRIEF.md
# Fast Interrupt Forcing Controller

This block sits between a set of interrupt request inputs and the two request paths of a processor: a normal, prioritized path and a single fast interrupt line. Each source passes through a two-flop synchronizer. It then goes through an optional polarity inversion and a per-source detector, which treats it either as an active level or as an active (rising) edge. A per-source forcing bit decides where the result goes. Unforced sources feed a masked pending vector that a priority arbiter would consume. Forced sources are removed from that vector and drive the active-low fast line instead. Source 0 is a dedicated fast source and is always routed to the fast line.

Software controls the block through a small word-addressed register bus. Forcing bits are changed only through a write-one-to-set register and a write-one-to-clear register, and their current value can be read back. Reading the fast vector register returns the programmed handler address. That read also acknowledges every latched edge-triggered fast request. A level-triggered fast request stays active until the external source goes inactive.

Register word addresses (3-bit `bus_addr`): 0 trigger mode (bit=1 edge, 0 level), 1 polarity (bit=1 active-low / falling edge), 2 normal enable, 3 force set (write one to set), 4 force clear (write one to clear), 5 force status (read), 6 fast vector (write sets address, read returns it and acknowledges), 7 normal edge pending (read; write one to clear). Bit i of each register belongs to source i.

Top module: `frc_fast_route`

## Requirements
- R1: After reset, the mode, polarity, enable and force registers read 0, `irq_pend_o` is 0 and `fiq_n_o` is 1.
- R2: Writing address 3 ORs the write data into the force status, and writing address 4 clears the status bits written as one. Zero bits leave the status unchanged. Address 5 reads the status.
- R3: A forced level-mode source drives `fiq_n_o` low while its active level is sampled and releases it when the level goes away. It never shows in `irq_pend_o`.
- R4: A forced edge-mode source latches a fast request on an active edge. `fiq_n_o` stays low after the input returns inactive. While forced, the edge sets no normal pending bit, so `irq_pend_o` stays 0 after the source is unforced.
- R5: A read of address 6 returns the value last written there and clears all latched edge fast requests, so `fiq_n_o` goes high when no level fast request is active.
- R6: A level-mode fast request is not cleared by a read of address 6.
- R7: An unforced level-mode source shows in `irq_pend_o` while active. An unforced edge-mode source latches bit i of `irq_pend_o`, which a one-write to address 7 clears. Neither touches `fiq_n_o`.
- R8: Source 0 drives `fiq_n_o` whatever its force bit holds, and `irq_pend_o[0]` is always 0.
- R9: A polarity bit of 1 makes the low input level active, and in edge mode the falling input edge active. Changing a polarity bit with a steady input creates no edge.
- R10: A normal enable bit of 0 hides that source from `irq_pend_o` without routing it to `fiq_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Asynchronous interrupt source inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address |
| irq_pend_o | output | N_SRC | Masked pending vector for the normal priority path |
| fiq_n_o | output | 1 | Active-low fast interrupt line |

## Verification
Several input patterns are applied to sources in both routing states.

- A held level on a forced source separates level following from latching.
- A short pulse on a forced edge source shows that the fast request is latched and that the vector read acknowledges it.
- A held level during a vector read shows that the acknowledge spares level requests.
- Inverted-polarity stimulus, including a polarity change with the input held still, separates true edges from spurious ones.
- The same pulses on unforced, masked and dedicated sources show which path each one reaches.

// File: rtl/frc_pkg.sv
package frc_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_MODE  = 3'd0,
        ADR_POL   = 3'd1,
        ADR_ENA   = 3'd2,
        ADR_FSET  = 3'd3,
        ADR_FCLR  = 3'd4,
        ADR_FSTAT = 3'd5,
        ADR_FVEC  = 3'd6,
        ADR_NPEND = 3'd7
    } frc_addr_e;
endpackage

// File: rtl/frc_sync.sv
module frc_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q, meta_d, out_q, out_d;

    always_comb begin
        meta_d = d;
        out_d  = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            out_q  <= '0;
        end else begin
            meta_q <= meta_d;
            out_q  <= out_d;
        end
    end

    assign q = out_q;
endmodule

// File: rtl/frc_edge.sv
module frc_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] s,
    input  logic [W-1:0] inv,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q, prev_d;

    always_comb prev_d = s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Raw history is kept, so a polarity change alone never looks like an edge.
        assign lvl[i]  = s[i] ^ inv[i];
        assign rise[i] = (s[i] ^ inv[i]) & ~(prev_q[i] ^ inv[i]);
    end
endmodule

// File: rtl/frc_fast_route.sv
module frc_fast_route
    import frc_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_SRC-1:0]  irq_pend_o,
    output logic              fiq_n_o
);
    localparam logic [N_SRC-1:0] DEDICATED = N_SRC'(1);

    typedef struct packed {
        logic [N_SRC-1:0]  mode;
        logic [N_SRC-1:0]  pol;
        logic [N_SRC-1:0]  ena;
        logic [N_SRC-1:0]  fstat;
        logic [N_SRC-1:0]  npend;
        logic [N_SRC-1:0]  fpend;
        logic [DATA_W-1:0] fvec;
    } state_t;

    state_t state_q, state_d;

    logic [N_SRC-1:0] src_s, lvl, rise, route, wbits, fast_req;
    logic             fack;

    frc_sync #(.W(N_SRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(src_i), .q(src_s)
    );

    frc_edge #(.W(N_SRC)) u_edge (
        .clk(clk), .rst_n(rst_n), .s(src_s), .inv(state_q.pol),
        .lvl(lvl), .rise(rise)
    );

    assign route = state_q.fstat | DEDICATED;
    assign wbits = bus_wdata[N_SRC-1:0];
    assign fack  = bus_rd && (bus_addr == ADR_FVEC);

    always_comb begin
        state_d = state_q;

        // Edge latching: the routing decides which flag an edge lands in.
        state_d.fpend = (fack ? '0 : state_q.fpend) | (rise & state_q.mode & route);
        state_d.npend = state_q.npend | (rise & state_q.mode & ~route);

        if (bus_wr) begin
            unique case (bus_addr)
                ADR_MODE:  state_d.mode  = wbits;
                ADR_POL:   state_d.pol   = wbits;
                ADR_ENA:   state_d.ena   = wbits;
                ADR_FSET:  state_d.fstat = state_q.fstat | wbits;
                ADR_FCLR:  state_d.fstat = state_q.fstat & ~wbits;
                ADR_FVEC:  state_d.fvec  = bus_wdata;
                ADR_NPEND: state_d.npend = (state_q.npend & ~wbits)
                                         | (rise & state_q.mode & ~route);
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (bus_addr)
            ADR_MODE:  bus_rdata = DATA_W'(state_q.mode);
            ADR_POL:   bus_rdata = DATA_W'(state_q.pol);
            ADR_ENA:   bus_rdata = DATA_W'(state_q.ena);
            ADR_FSTAT: bus_rdata = DATA_W'(state_q.fstat);
            ADR_FVEC:  bus_rdata = state_q.fvec;
            ADR_NPEND: bus_rdata = DATA_W'(state_q.npend);
            default:   bus_rdata = '0;
        endcase
    end

    assign fast_req   = route & ((state_q.mode & state_q.fpend) | (~state_q.mode & lvl));
    assign fiq_n_o    = ~(|fast_req);
    assign irq_pend_o = ~route & state_q.ena
                      & ((state_q.mode & state_q.npend) | (~state_q.mode & lvl));
endmodule

// File: rtl/frc_fast_route_chk.sv
module frc_fast_route_chk
    import frc_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N_SRC-1:0]  wbits,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_SRC-1:0]  irq_pend_o,
    input logic [N_SRC-1:0]  fstat,
    input logic [DATA_W-1:0] fvec
);
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_FSET) |=> fstat == ($past(fstat) | $past(wbits)));

    p_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_FCLR) |=> fstat == ($past(fstat) & ~$past(wbits)));

    p_forced_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend_o & fstat) == '0);

    p_vec_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADR_FVEC) |-> bus_rdata == fvec);

    p_src0_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pend_o[0]);
endmodule

bind frc_fast_route frc_fast_route_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .wbits(bus_wdata[N_SRC-1:0]), .bus_rdata(bus_rdata),
    .irq_pend_o(irq_pend_o), .fstat(state_q.fstat), .fvec(state_q.fvec)
);

// File: tb/tb_frc_fast_route.sv
`timescale 1ns/1ps
module tb_frc_fast_route;
    localparam int N = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  irq_pend;
    logic          fiq_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    frc_fast_route #(.N_SRC(N), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pend_o(irq_pend), .fiq_n_o(fiq_n)
    );

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        check("R1 fiq", DW'(fiq_n), 1);
        check("R1 irq", DW'(irq_pend), 0);
        rd(3'd5, v); check("R1 fstat", v, 0);
        rd(3'd0, v); check("R1 mode", v, 0);
        rd(3'd2, v); check("R1 ena", v, 0);
    endtask

    task automatic t_force_regs();
        logic [DW-1:0] v;
        wr(3'd3, 32'h0A); rd(3'd5, v); check("R2 set", v, 32'h0A);
        wr(3'd3, 32'h04); rd(3'd5, v); check("R2 set keeps", v, 32'h0E);
        wr(3'd4, 32'h02); rd(3'd5, v); check("R2 clr", v, 32'h0C);
        wr(3'd4, 32'h0C); rd(3'd5, v); check("R2 clr all", v, 32'h00);
    endtask

    task automatic t_level_forced();
        wr(3'd2, 32'hFF);
        wr(3'd3, 32'h08);
        src[3] = 1'b1; wait_cyc(4);
        check("R3 fiq low", DW'(fiq_n), 0);
        check("R3 hidden", DW'(irq_pend), 0);
        src[3] = 1'b0; wait_cyc(4);
        check("R3 fiq release", DW'(fiq_n), 1);
    endtask

    task automatic t_edge_forced_ack();
        logic [DW-1:0] v;
        wr(3'd6, 32'h1234_5670);
        wr(3'd0, 32'h04);
        wr(3'd3, 32'h04);
        src[2] = 1'b1; wait_cyc(3); src[2] = 1'b0; wait_cyc(4);
        check("R4 latched", DW'(fiq_n), 0);
        check("R4 hidden", DW'(irq_pend), 0);
        rd(3'd6, v); check("R5 vec", v, 32'h1234_5670);
        wait_cyc(2);
        check("R5 ack release", DW'(fiq_n), 1);
        wr(3'd4, 32'h04);
        wait_cyc(2);
        check("R4 no normal after unforce", DW'(irq_pend), 0);
        wr(3'd0, 32'h00);
    endtask

    task automatic t_level_survives_ack();
        logic [DW-1:0] v;
        src[3] = 1'b1; wait_cyc(4);
        rd(3'd6, v); wait_cyc(2);
        check("R6 level kept", DW'(fiq_n), 0);
        src[3] = 1'b0; wait_cyc(4);
        check("R6 release", DW'(fiq_n), 1);
        wr(3'd4, 32'h08);
    endtask

    task automatic t_normal();
        logic [DW-1:0] v;
        src[4] = 1'b1; wait_cyc(4);
        check("R7 level irq", DW'(irq_pend), 32'h10);
        check("R7 no fiq", DW'(fiq_n), 1);
        src[4] = 1'b0; wait_cyc(4);
        check("R7 level drop", DW'(irq_pend), 0);
        wr(3'd0, 32'h20);
        src[5] = 1'b1; wait_cyc(3); src[5] = 1'b0; wait_cyc(4);
        check("R7 edge latched", DW'(irq_pend), 32'h20);
        rd(3'd7, v); check("R7 npend read", v, 32'h20);
        wr(3'd7, 32'h20); wait_cyc(1);
        check("R7 edge cleared", DW'(irq_pend), 0);
        wr(3'd0, 32'h00);
    endtask

    task automatic t_src0();
        src[0] = 1'b1; wait_cyc(4);
        check("R8 fiq", DW'(fiq_n), 0);
        check("R8 no irq", DW'(irq_pend), 0);
        src[0] = 1'b0; wait_cyc(4);
        check("R8 release", DW'(fiq_n), 1);
    endtask

    task automatic t_polarity();
        wr(3'd1, 32'h40); wait_cyc(1);
        check("R9 active low level", DW'(irq_pend), 32'h40);
        wr(3'd0, 32'h40); wait_cyc(2);
        check("R9 no spurious edge", DW'(irq_pend), 0);
        src[6] = 1'b1; wait_cyc(4);
        check("R9 rising ignored", DW'(irq_pend), 0);
        src[6] = 1'b0; wait_cyc(4);
        check("R9 falling edge", DW'(irq_pend), 32'h40);
        wr(3'd7, 32'h40);
        wr(3'd1, 32'h00); wait_cyc(2);
        check("R9 pol change no edge", DW'(irq_pend), 0);
        wr(3'd0, 32'h00);
    endtask

    task automatic t_enable();
        wr(3'd2, 32'hEF);
        src[4] = 1'b1; wait_cyc(4);
        check("R10 masked", DW'(irq_pend), 0);
        check("R10 not fast", DW'(fiq_n), 1);
        wr(3'd2, 32'hFF); wait_cyc(1);
        check("R10 unmasked", DW'(irq_pend), 32'h10);
        src[4] = 1'b0; wait_cyc(4);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_force_regs();
        t_level_forced();
        t_edge_forced_ack();
        t_level_survives_ack();
        t_normal();
        t_src0();
        t_polarity();
        t_enable();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule